// File: doc/BRIEF.md
# Sub-Pixel Programmable Clock Edge Generator

This block produces the fast clocks that read out an image sensor line: a reset-gate pulse, a last-stage horizontal clock, four horizontal drivers and two sample strobes for correlated double sampling. A fast clock at 64 times the pixel rate steps a phase counter through the 64 slots of one pixel period. Every output edge falls on one of these slots, and the slot is chosen by a register. So the timing of each output can be tuned to one sixty-fourth of a pixel, and no fixed division ratio applies.

The edge positions, the polarity bits and a divide-by-two control are written through a simple write port. Writes land in a shadow copy. The copy becomes active only when the phase counter wraps to slot 0, so no pixel ever mixes old and new settings. When the divide-by-two control is on, the block accepts a reference at twice the fast rate and advances one phase every second clock.

Top module: `subpixel_clkgen`

## Requirements
- R1: A synchronous active-high reset sets the phase to 0 and loads the default settings. While reset is asserted and in the cycle after it, every output is low. The defaults are: reset gate 8/16, last-horizontal 32/60, H1 1/33 and H2 33/1 (written rise/fall), sample strobes at 24 and 56, all polarities 0, and divide-by-two off. The first sample strobe after release appears in the 24th clock.
- R2: The phase moves one slot per clock and wraps from 63 to 0. With divide-by-two off, one sample strobe appears every 64 clocks.
- R3: A level output turns active in the phase equal to its rise position and turns inactive in the phase equal to its fall position. When the rise position is greater than the fall position, the active window wraps across the pixel boundary.
- R4: A polarity bit of 1 inverts its output, so the inactive level becomes high.
- R5: A level output whose rise and fall positions are equal stays at its inactive level (the value of its polarity bit) for the whole pixel.
- R6: H3 repeats H1 and H4 repeats H2 in every cycle, using the same positions and polarity.
- R7: Each of the two sample strobes is a one-clock high pulse in the first clock of the phase equal to its programmed position, once per pixel.
- R8: Divide-by-two is set by bit 0 of address 11. When it is on, each phase lasts two clocks: level outputs hold for both clocks, strobes appear only in the first, and a pixel takes 128 clocks.
- R9: A setting written during a pixel does not affect the rest of that pixel. It takes effect from the next phase 0.
- R10: Address map, with the data 6 bits wide. Address 2c holds the rise position of channel c and address 2c+1 its fall position, with channels 0 = reset gate, 1 = last-horizontal, 2 = H1, 3 = H2. Address 8 holds the first strobe position and address 9 the second. Address 10 holds the polarity bits, with bit c for channel c. Address 11 bit 0 holds divide-by-two. Writes to addresses 12 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock: 64x the pixel rate, or 128x with divide-by-two on |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 6 | Register write data |
| rg_o | output | 1 | Reset-gate pulse |
| hl_o | output | 1 | Last-horizontal clock |
| h1_o | output | 1 | Horizontal driver 1 |
| h2_o | output | 1 | Horizontal driver 2 |
| h3_o | output | 1 | Horizontal driver 3 (follows H1) |
| h4_o | output | 1 | Horizontal driver 4 (follows H2) |
| shp_o | output | 1 | Reset-level sample strobe |
| shd_o | output | 1 | Data-level sample strobe |

## Verification
The hardest case to reach is a write that lands in the middle of a pixel, because the new setting must not take effect until the next wrap. The bench locks onto the phase by waiting for the first sample strobe, whose slot it knows. It then writes a new reset-gate window at a known phase and checks the old window through the end of that pixel. After the wrap it checks the new window. Wrapped windows, equal edges and divide-by-two are each checked across a whole pixel, and only after the bench has let a full pixel pass so that the level registers have settled.

// File: rtl/spclk_pkg.sv
package spclk_pkg;
  // Level channels that own a rise/fall/polarity set.
  localparam int unsigned N_LVL  = 4;
  localparam int unsigned CH_RG  = 0;
  localparam int unsigned CH_HL  = 1;
  localparam int unsigned CH_H1  = 2;
  localparam int unsigned CH_H2  = 3;
  // Physical level outputs: rg, hl, h1, h2, h3, h4.
  localparam int unsigned N_OUT  = 6;

  // Register offsets after the per-channel rise/fall pairs.
  localparam int unsigned OFS_SHP = 2 * N_LVL;
  localparam int unsigned OFS_SHD = 2 * N_LVL + 1;
  localparam int unsigned OFS_POL = 2 * N_LVL + 2;
  localparam int unsigned OFS_DIV = 2 * N_LVL + 3;

  // Which configuration channel drives each physical output.
  function automatic int unsigned out_src(int unsigned k);
    case (k)
      0: return CH_RG;
      1: return CH_HL;
      2: return CH_H1;
      3: return CH_H2;
      4: return CH_H1;
      default: return CH_H2;
    endcase
  endfunction

  // Reset defaults, scaled to the number of phase slots.
  function automatic int unsigned def_rise(int unsigned ch, int unsigned w);
    int unsigned n;
    n = 1 << w;
    case (ch)
      CH_RG: return n / 8;
      CH_HL: return n / 2;
      CH_H1: return 1;
      default: return n / 2 + 1;
    endcase
  endfunction

  function automatic int unsigned def_fall(int unsigned ch, int unsigned w);
    int unsigned n;
    n = 1 << w;
    case (ch)
      CH_RG: return n / 4;
      CH_HL: return n - n / 16;
      CH_H1: return n / 2 + 1;
      default: return 1;
    endcase
  endfunction

  function automatic int unsigned def_shp(int unsigned w);
    return (3 * (1 << w)) / 8;
  endfunction

  function automatic int unsigned def_shd(int unsigned w);
    return (7 * (1 << w)) / 8;
  endfunction
endpackage

// File: rtl/spclk_phase_ctr.sv
module spclk_phase_ctr #(
  parameter int unsigned PH_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            div2_i,
  output logic            adv_o,
  output logic            wrap_o,
  output logic [PH_W-1:0] ph_o,
  output logic [PH_W-1:0] ph_nxt_o
);
  localparam logic [PH_W-1:0] PH_MAX = '1;

  logic            tick_q;
  logic [PH_W-1:0] ph_q;

  // With divide-by-two on, only every second clock advances the phase.
  assign adv_o    = ~div2_i | tick_q;
  assign wrap_o   = adv_o & (ph_q == PH_MAX);
  assign ph_nxt_o = adv_o ? ph_q + 1'b1 : ph_q;
  assign ph_o     = ph_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q <= 1'b0;
      ph_q   <= '0;
    end else begin
      tick_q <= div2_i ? ~tick_q : 1'b0;
      ph_q   <= ph_nxt_o;
    end
  end

  // R2: the last slot wraps back to slot 0
  a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> (ph_o == '0));
  // R2: an advance steps by exactly one slot
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (adv_o && !wrap_o) |=> (ph_o == $past(ph_o) + 1'b1));
  // R8: a clock without an advance keeps the phase
  a_r8_idle: assert property (@(posedge clk) disable iff (rst)
    !adv_o |=> (ph_o == $past(ph_o)));
  // R8: with divide-by-two, advances alternate with idle clocks
  a_r8_alt: assert property (@(posedge clk) disable iff (rst)
    (div2_i && adv_o && !wrap_o) |=> !adv_o);
endmodule

// File: rtl/spclk_cfg_bank.sv
module spclk_cfg_bank
  import spclk_pkg::*;
#(
  parameter int unsigned PH_W   = 6,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [PH_W-1:0]            wr_data_i,
  input  logic                       load_i,
  output logic [N_LVL-1:0][PH_W-1:0] rise_o,
  output logic [N_LVL-1:0][PH_W-1:0] fall_o,
  output logic [N_LVL-1:0]           pol_o,
  output logic [PH_W-1:0]            shp_o,
  output logic [PH_W-1:0]            shd_o,
  output logic                       div2_o
);
  // Shadow copy, written at any time.
  logic [PH_W-1:0]  sh_rise [N_LVL];
  logic [PH_W-1:0]  sh_fall [N_LVL];
  logic [N_LVL-1:0] sh_pol;
  logic [PH_W-1:0]  sh_shp, sh_shd;
  logic             sh_div2;
  // Active copy, refreshed only at the pixel boundary.
  logic [PH_W-1:0]  act_rise [N_LVL];
  logic [PH_W-1:0]  act_fall [N_LVL];
  logic [N_LVL-1:0] act_pol;
  logic [PH_W-1:0]  act_shp, act_shd;
  logic             act_div2;

  function automatic logic hit(logic [ADDR_W-1:0] a, int unsigned ofs);
    return a == ADDR_W'(ofs);
  endfunction

  for (genvar c = 0; c < N_LVL; c++) begin : g_lvl_shadow
    always_ff @(posedge clk) begin
      if (rst) begin
        sh_rise[c] <= PH_W'(def_rise(c, PH_W));
        sh_fall[c] <= PH_W'(def_fall(c, PH_W));
      end else if (wr_en_i) begin
        if (hit(wr_addr_i, 2 * c))     sh_rise[c] <= wr_data_i;
        if (hit(wr_addr_i, 2 * c + 1)) sh_fall[c] <= wr_data_i;
      end
    end
    // The boundary cycle already sees the shadow, so the new pixel starts clean.
    assign rise_o[c] = load_i ? sh_rise[c] : act_rise[c];
    assign fall_o[c] = load_i ? sh_fall[c] : act_fall[c];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_pol  <= '0;
      sh_shp  <= PH_W'(def_shp(PH_W));
      sh_shd  <= PH_W'(def_shd(PH_W));
      sh_div2 <= 1'b0;
    end else if (wr_en_i) begin
      if (hit(wr_addr_i, OFS_POL)) sh_pol  <= N_LVL'(wr_data_i);
      if (hit(wr_addr_i, OFS_SHP)) sh_shp  <= wr_data_i;
      if (hit(wr_addr_i, OFS_SHD)) sh_shd  <= wr_data_i;
      if (hit(wr_addr_i, OFS_DIV)) sh_div2 <= wr_data_i[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < N_LVL; c++) begin
        act_rise[c] <= PH_W'(def_rise(c, PH_W));
        act_fall[c] <= PH_W'(def_fall(c, PH_W));
      end
      act_pol  <= '0;
      act_shp  <= PH_W'(def_shp(PH_W));
      act_shd  <= PH_W'(def_shd(PH_W));
      act_div2 <= 1'b0;
    end else if (load_i) begin
      act_rise <= sh_rise;
      act_fall <= sh_fall;
      act_pol  <= sh_pol;
      act_shp  <= sh_shp;
      act_shd  <= sh_shd;
      act_div2 <= sh_div2;
    end
  end

  assign pol_o  = load_i ? sh_pol : act_pol;
  assign shp_o  = load_i ? sh_shp : act_shp;
  assign shd_o  = load_i ? sh_shd : act_shd;
  // The rate control feeds the phase counter, so it switches one cycle later.
  assign div2_o = act_div2;

  // R9: away from the boundary the active settings do not move
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> ($stable(act_shp) && $stable(act_pol) && $stable(act_div2)));
  // R9: at the boundary the shadow is taken over
  a_r9_take: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (act_shd == $past(sh_shd)));
endmodule

// File: rtl/spclk_edge_ch.sv
module spclk_edge_ch #(
  parameter int unsigned PH_W  = 6,
  parameter bit          PULSE = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            adv_i,
  input  logic [PH_W-1:0] ph_nxt_i,
  input  logic [PH_W-1:0] rise_i,
  input  logic [PH_W-1:0] fall_i,
  input  logic            pol_i,
  output logic            out_o
);
  if (PULSE) begin : g_pulse
    // Strobe: one clock high on the first clock of the chosen slot.
    logic unused_pulse;
    assign unused_pulse = ^{fall_i, pol_i};
    always_ff @(posedge clk) begin
      if (rst) out_o <= 1'b0;
      else     out_o <= adv_i && (ph_nxt_i == rise_i);
    end
  end else begin : g_level
    logic lvl_q, lvl_d;
    always_comb begin
      lvl_d = lvl_q;
      if (rise_i == fall_i)                  lvl_d = 1'b0;
      else if (adv_i && ph_nxt_i == rise_i)  lvl_d = 1'b1;
      else if (adv_i && ph_nxt_i == fall_i)  lvl_d = 1'b0;
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        lvl_q <= 1'b0;
        out_o <= 1'b0;
      end else begin
        lvl_q <= lvl_d;
        out_o <= lvl_d ^ pol_i;
      end
    end

    // R5: equal edges hold the inactive level
    a_r5_equal_idle: assert property (@(posedge clk) disable iff (rst)
      (rise_i == fall_i) |=> (out_o == $past(pol_i)));
    // R3 / R4: entering the rise slot drives the active level
    a_r3_rise: assert property (@(posedge clk) disable iff (rst)
      (adv_i && rise_i != fall_i && ph_nxt_i == rise_i) |=> (out_o != $past(pol_i)));
    // R3 / R4: entering the fall slot drives the inactive level
    a_r3_fall: assert property (@(posedge clk) disable iff (rst)
      (adv_i && rise_i != fall_i && ph_nxt_i == fall_i) |=> (out_o == $past(pol_i)));
  end
endmodule

// File: rtl/subpixel_clkgen.sv
module subpixel_clkgen
  import spclk_pkg::*;
#(
  parameter int unsigned PH_W   = 6,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [PH_W-1:0]   wr_data,
  output logic              rg_o,
  output logic              hl_o,
  output logic              h1_o,
  output logic              h2_o,
  output logic              h3_o,
  output logic              h4_o,
  output logic              shp_o,
  output logic              shd_o
);
  logic                       adv, wrap, div2;
  logic [PH_W-1:0]            ph, ph_nxt;
  logic [N_LVL-1:0][PH_W-1:0] rise_eff, fall_eff;
  logic [N_LVL-1:0]           pol_eff;
  logic [PH_W-1:0]            shp_eff, shd_eff;
  logic [N_OUT-1:0]           lvl_out;

  spclk_phase_ctr #(.PH_W(PH_W)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .div2_i   (div2),
    .adv_o    (adv),
    .wrap_o   (wrap),
    .ph_o     (ph),
    .ph_nxt_o (ph_nxt)
  );

  spclk_cfg_bank #(.PH_W(PH_W), .ADDR_W(ADDR_W)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .load_i    (wrap),
    .rise_o    (rise_eff),
    .fall_o    (fall_eff),
    .pol_o     (pol_eff),
    .shp_o     (shp_eff),
    .shd_o     (shd_eff),
    .div2_o    (div2)
  );

  // One registered channel per physical pin; H3/H4 reuse H1/H2 settings.
  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    localparam int unsigned SRC = out_src(k);
    spclk_edge_ch #(.PH_W(PH_W), .PULSE(1'b0)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .adv_i    (adv),
      .ph_nxt_i (ph_nxt),
      .rise_i   (rise_eff[SRC]),
      .fall_i   (fall_eff[SRC]),
      .pol_i    (pol_eff[SRC]),
      .out_o    (lvl_out[k])
    );
  end

  spclk_edge_ch #(.PH_W(PH_W), .PULSE(1'b1)) u_shp (
    .clk      (clk),
    .rst      (rst),
    .adv_i    (adv),
    .ph_nxt_i (ph_nxt),
    .rise_i   (shp_eff),
    .fall_i   (shp_eff),
    .pol_i    (1'b0),
    .out_o    (shp_o)
  );

  spclk_edge_ch #(.PH_W(PH_W), .PULSE(1'b1)) u_shd (
    .clk      (clk),
    .rst      (rst),
    .adv_i    (adv),
    .ph_nxt_i (ph_nxt),
    .rise_i   (shd_eff),
    .fall_i   (shd_eff),
    .pol_i    (1'b0),
    .out_o    (shd_o)
  );

  assign rg_o = lvl_out[0];
  assign hl_o = lvl_out[1];
  assign h1_o = lvl_out[2];
  assign h2_o = lvl_out[3];
  assign h3_o = lvl_out[4];
  assign h4_o = lvl_out[5];

  // R7: a strobe is only seen while the counter sits on its programmed slot
  a_r7_shp_slot: assert property (@(posedge clk) disable iff (rst)
    (shp_o && !wrap) |-> (ph == shp_eff));
  a_r7_shd_slot: assert property (@(posedge clk) disable iff (rst)
    (shd_o && !wrap) |-> (ph == shd_eff));
endmodule

// File: tb/subpixel_clkgen_bench.sv
module subpixel_clkgen_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [5:0] wr_data = '0;
  logic rg, hl, h1, h2, h3, h4, shp, shd;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  // Bench-side picture of the settings, from the address map of R10.
  int br[4];
  int bf[4];
  bit bpol[4];
  int bshp, bshd;
  bit bdiv;

  always #2.5 clk = ~clk;

  subpixel_clkgen u_subpixel_clkgen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rg_o(rg), .hl_o(hl), .h1_o(h1), .h2_o(h2), .h3_o(h3), .h4_o(h4),
    .shp_o(shp), .shd_o(shd)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL R2 watchdog: got %0d cycles exp under 100000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(bit ok, string req, string what, int got, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d exp %0d", req, what, got, exp);
    end
  endtask

  function automatic int src_of(int s);
    case (s)
      0: return 0;
      1: return 1;
      2: return 2;
      3: return 3;
      4: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic bit exp_lvl(int p, int r, int f, bit pol);
    bit a;
    if (r == f)     a = 1'b0;
    else if (r < f) a = (p >= r) && (p < f);
    else            a = (p >= r) || (p < f);
    return a ^ pol;
  endfunction

  task automatic set_defaults();
    br[0] = 8;  bf[0] = 16;
    br[1] = 32; bf[1] = 60;
    br[2] = 1;  bf[2] = 33;
    br[3] = 33; bf[3] = 1;
    for (int c = 0; c < 4; c++) bpol[c] = 1'b0;
    bshp = 24; bshd = 56; bdiv = 1'b0;
  endtask

  // Called at a falling edge; the write lands on the next rising edge.
  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 6'(d);
    @(negedge clk);
    wr_en = 1'b0;
    if (a < 8) begin
      if (a % 2 == 0) br[a / 2] = d; else bf[a / 2] = d;
    end else if (a == 8)  bshp = d;
    else if (a == 9)  bshd = d;
    else if (a == 10) for (int c = 0; c < 4; c++) bpol[c] = d[c];
    else if (a == 11) bdiv = d[0];
  endtask

  // Leaves the bench at the falling edge inside the first clock of slot bshp,
  // after the current settings have run for a full pixel.
  task automatic sync(string req);
    int seen = 0;
    int n = 0;
    while (seen < 3 && n < 600) begin
      @(negedge clk);
      n++;
      if (shp) seen++;
    end
    chk(seen == 3, req, "strobe lock", seen, 3);
  endtask

  task automatic scan(string req);
    string nm[8] = '{"rg", "hl", "h1", "h2", "h3", "h4", "shp", "shd"};
    int step = bdiv ? 2 : 1;
    int bad[8];
    int fph[8];
    int fgot[8];
    int fexp[8];
    logic [7:0] got, exp;
    for (int s = 0; s < 8; s++) bad[s] = 0;
    for (int i = 0; i < 64; i++) begin
      int p = (bshp + i) % 64;
      for (int k = 0; k < step; k++) begin
        got = {shd, shp, h4, h3, h2, h1, hl, rg};
        for (int s = 0; s < 6; s++) exp[s] = exp_lvl(p, br[src_of(s)], bf[src_of(s)], bpol[src_of(s)]);
        exp[6] = (k == 0) && (p == bshp);
        exp[7] = (k == 0) && (p == bshd);
        for (int s = 0; s < 8; s++) begin
          if (got[s] !== exp[s]) begin
            if (bad[s] == 0) begin
              fph[s] = p; fgot[s] = int'(got[s]); fexp[s] = int'(exp[s]);
            end
            bad[s]++;
          end
        end
        @(negedge clk);
      end
    end
    for (int s = 0; s < 8; s++)
      chk(bad[s] == 0, req, $sformatf("%s first wrong at phase %0d", nm[s], fph[s]),
          fgot[s], fexp[s]);
  endtask

  task automatic period(string req);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!shp && n < 300);
    chk(n == (bdiv ? 128 : 64), req, "clocks between strobes", n, bdiv ? 128 : 64);
  endtask

  // R1: outputs during reset and first strobe timing after release
  task automatic t_reset();
    int n = 0;
    repeat (4) @(negedge clk);
    chk({rg, hl, h1, h2, h3, h4, shp, shd} == 8'h00, "R1", "outputs in reset",
        int'({rg, hl, h1, h2, h3, h4, shp, shd}), 0);
    rst = 1'b0;
    set_defaults();
    do begin
      @(negedge clk);
      n++;
    end while (!shp && n < 200);
    chk(n == 24, "R1", "clocks to first strobe", n, 24);
  endtask

  // R3 / R6 / R7 with defaults, R2 pixel length
  task automatic t_default();
    sync("R3");
    scan("R3");
    period("R2");
  endtask

  // R9: a mid-pixel write waits for the next slot 0
  task automatic t_shadow();
    int bad = 0;
    int got10, got45;
    // Here the bench sits in slot 24 (strobe clock).
    wr(0, 40);
    wr(1, 50);
    for (int p = 26; p < 64; p++) begin
      if (rg !== 1'b0) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R9", "rg changed before the boundary", bad, 0);
    repeat (10) @(negedge clk);
    got10 = int'(rg);
    chk(rg === 1'b0, "R9", "rg at slot 10 of new pixel", got10, 0);
    repeat (35) @(negedge clk);
    got45 = int'(rg);
    chk(rg === 1'b1, "R9", "rg at slot 45 of new pixel", got45, 1);
  endtask

  // R3 wrap, R4 polarity, R6 followers, R7 strobes at slots 0 and 63
  task automatic t_custom();
    wr(0, 50); wr(1, 10);
    wr(2, 5);  wr(3, 6);
    wr(4, 0);  wr(5, 32);
    wr(6, 32); wr(7, 0);
    wr(8, 0);  wr(9, 63);
    wr(10, 6'b001001);
    sync("R4");
    scan("R4");
    scan("R6");
  endtask

  // R10: unused addresses leave every output as it was
  task automatic t_ignore();
    wr(12, 63); wr(13, 63); wr(14, 63); wr(15, 63);
    sync("R10");
    scan("R10");
  endtask

  // R5: equal edges, with both polarities
  task automatic t_equal();
    wr(2, 20); wr(3, 20);
    wr(6, 40); wr(7, 40);
    wr(10, 6'b000010);
    sync("R5");
    scan("R5");
  endtask

  // R8: divide-by-two
  task automatic t_div2();
    wr(8, 12); wr(9, 44);
    wr(11, 1);
    sync("R8");
    scan("R8");
    period("R8");
  endtask

  // R1: reset in mid run restores defaults and rate
  task automatic t_rst_mid();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk({rg, hl, h1, h2, h3, h4, shp, shd} == 8'h00, "R1", "outputs in mid-run reset",
        int'({rg, hl, h1, h2, h3, h4, shp, shd}), 0);
    rst = 1'b0;
    set_defaults();
    sync("R1");
    scan("R1");
    period("R2");
  endtask

  initial begin
    set_defaults();
    t_reset();
    t_default();
    t_shadow();
    t_custom();
    t_ignore();
    t_equal();
    t_div2();
    t_rst_mid();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule